// File: doc/BRIEF.md
# Byte-Register SPI Flash Command Engine

This block is a host-driven SPI master for serial flash parts. The host programs it through a narrow window of byte-wide registers. It loads an opcode into its own register and a packed pair of byte counts into a second register. It places any payload bytes into an eight-slot ring buffer through a single data port. It then writes a start bit. The engine lowers chip select and sends the opcode first. It then clocks out one byte for each payload slot and one more byte for each requested response byte. The byte returned by the flash during every post-opcode byte is written back into the ring at the current pointer.

Transmit and receive share the same ring and the same 3-bit pointer, and the ring is never cleared. Suppose the host zeroes the pointer, writes W payload bytes, zeroes the pointer again and starts a command with R response bytes. The response then sits in slots W through W+R-1, and the pointer ends at W+R modulo 8. The host reads the response by zeroing the pointer and stepping through the data port. A two-bit field selects one of three SPI clock rates derived from the system clock.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset chip select is high, SCK is low, busy is 0, the pointer is 0 and the speed field (bits 5:4 of address 0xD) reads 1, so address 0xD reads 8'h10.
- R2: A write to the data port (address 0xC) stores the byte in the slot at the pointer. A read of the data port returns that slot. Either access advances the pointer by one, modulo 8. The pointer reads back in bits 2:0 of address 0xD.
- R3: Writing a 1 to bit 4 of the control register (address 2) sets the pointer to 0. When the same write also sets bit 0, the command starts from slot 0.
- R4: Writing a 1 to bit 0 of address 2 while idle starts a command. Bit 0 of address 2 and the busy output then read 1 until the command ends, after which both read 0.
- R5: During a command chip select stays low. The first byte sent is the opcode register (address 0). The next W bytes come from the ring starting at the pointer, followed by R further ring bytes, for 1+W+R bytes in total. Transfers use SPI mode 0, most significant bit first.
- R6: For every byte after the opcode, the byte received on MISO is stored at the pointer and the pointer advances. After the command the pointer equals its start value plus W+R, modulo 8. With W equal to 0, exactly R bytes are captured.
- R7: In the count register (address 1), bits 3:0 give W and bits 7:4 give R. A value above 8 acts as 8. The register reads back exactly as written, also after a command.
- R8: The SCK period is 2*(S+1) system clocks for speed field S equal to 1, 2 or 3. S equal to 0 behaves as 1.
- R9: While busy, every host write is ignored, and data-port reads do not move the pointer.
- R10: SCK is low whenever chip select is high. Chip select falls at least one SCK period before the first rising SCK edge and rises only after the last falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regSel | input | 4 | Register byte address |
| wrEn | input | 1 | Host write strobe |
| rdEn | input | 1 | Host read strobe (advances the pointer on the data port) |
| wrData | input | 8 | Host write data |
| rdData | output | 8 | Read data for the selected register, combinational |
| busy | output | 1 | Command in progress |
| spiSck | output | 1 | SPI clock |
| spiCsN | output | 1 | Chip select, active low |
| spiMosi | output | 1 | Serial data to the flash |
| spiMiso | input | 1 | Serial data from the flash |

## Verification
A single control write can clear the pointer and start a command in the same cycle. The bench provokes this by first moving the pointer to 3 and then writing 8'h11 to the control register. It judges the result from the payload bytes the flash model sees and from the final pointer, which must be W+R rather than 3+W+R. A second collision is between a running command and host accesses in the same cycles: writes to the count, opcode and data port, and a data-port read, are issued while busy. The count readback, the opcode on the wire and the final pointer and ring contents must show none of those accesses.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  localparam logic [3:0] ADR_OPCODE = 4'h0;
  localparam logic [3:0] ADR_COUNT  = 4'h1;
  localparam logic [3:0] ADR_CTRL   = 4'h2;
  localparam logic [3:0] ADR_FIFO   = 4'hC;
  localparam logic [3:0] ADR_PTR    = 4'hD;

  typedef struct packed {
    logic loadOp;    // load opcode into transmit shifter
    logic loadNext;  // load next ring byte into transmit shifter
    logic shiftOut;  // advance transmit shifter by one bit
    logic sample;    // capture MISO into receive shifter
    logic storeRx;   // write receive shifter into ring, bump pointer
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_TAIL
  } engState_t;

endpackage

// File: rtl/spi_eng_dp.sv
module spi_eng_dp
  import spi_eng_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       regSel,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData,
  input  logic             busy,
  input  dpStrobe_t        strobe,
  input  logic             spiMiso,
  output logic             spiMosi,
  output logic             startReq,
  output logic [CNT_W-1:0] txCount,
  output logic [CNT_W-1:0] rxCount,
  output logic [1:0]       speedSel,
  output logic [PTR_W-1:0] ptrQ,
  output logic [7:0]       cntQ
);

  logic [7:0]       opReg;
  logic [7:0]       cntReg;
  logic [1:0]       speedReg;
  logic [7:0]       ring [DEPTH];
  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] ptrInc;
  logic [7:0]       txSh;
  logic [7:0]       rxSh;

  logic hostWr, fifoWr, fifoRd, ctrlWr, ptrClr;

  assign hostWr   = wrEn && !busy;
  assign fifoWr   = hostWr && (regSel == ADR_FIFO);
  assign fifoRd   = rdEn && !busy && (regSel == ADR_FIFO);
  assign ctrlWr   = hostWr && (regSel == ADR_CTRL);
  assign startReq = ctrlWr && wrData[0];
  assign ptrClr   = ctrlWr && wrData[4];
  assign ptrInc   = ptr + PTR_W'(1);

  function automatic logic [CNT_W-1:0] clampCnt(input logic [3:0] n);
    return (int'(n) > DEPTH) ? CNT_W'(DEPTH) : CNT_W'(n);
  endfunction

  assign txCount  = clampCnt(cntReg[3:0]);
  assign rxCount  = clampCnt(cntReg[7:4]);
  assign speedSel = speedReg;
  assign ptrQ     = ptr;
  assign cntQ     = cntReg;
  assign spiMosi  = txSh[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg    <= '0;
      cntReg   <= '0;
      speedReg <= 2'd1;
    end else if (hostWr) begin
      if (regSel == ADR_OPCODE) opReg    <= wrData;
      if (regSel == ADR_COUNT)  cntReg   <= wrData;
      if (regSel == ADR_PTR)    speedReg <= wrData[5:4];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  ptr <= '0;
    else if (ptrClr)                            ptr <= '0;
    else if (fifoWr || fifoRd || strobe.storeRx) ptr <= ptrInc;
  end

  // ring contents are deliberately left without reset
  always_ff @(posedge clk) begin
    if (fifoWr)              ring[ptr] <= wrData;
    else if (strobe.storeRx) ring[ptr] <= rxSh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh <= '0;
      rxSh <= '0;
    end else begin
      if (strobe.loadOp)        txSh <= opReg;
      else if (strobe.loadNext) txSh <= ring[strobe.storeRx ? ptrInc : ptr];
      else if (strobe.shiftOut) txSh <= {txSh[6:0], 1'b0};
      if (strobe.sample)        rxSh <= {rxSh[6:0], spiMiso};
    end
  end

  always_comb begin
    rdData = '0;
    case (regSel)
      ADR_OPCODE: rdData = opReg;
      ADR_COUNT:  rdData = cntReg;
      ADR_CTRL:   rdData[0] = busy;
      ADR_FIFO:   rdData = ring[ptr];
      ADR_PTR: begin
        rdData[5:4]       = speedReg;
        rdData[PTR_W-1:0] = ptr;
      end
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/spi_eng_ctrl.sv
module spi_eng_ctrl
  import spi_eng_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int HALF_UNIT = 1,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1),
  localparam int MAX_HALF = HALF_UNIT * 4,
  localparam int DIV_W    = $clog2(2 * MAX_HALF) + 1,
  localparam int BYTE_W   = $clog2(2 * MAX_BYTES + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [1:0]       speedSel,
  output dpStrobe_t        strobe,
  output logic             busy,
  output logic             spiSck,
  output logic             spiCsN
);

  engState_t         state;
  logic [DIV_W-1:0]  divCnt;
  logic [DIV_W-1:0]  halfLen;
  logic [DIV_W-1:0]  leadLen;
  logic [2:0]        bitCnt;
  logic [BYTE_W-1:0] byteIdx;
  logic [BYTE_W-1:0] lastIdx;
  logic              tick, leadDone, lastByte;

  always_comb begin
    halfLen = DIV_W'(HALF_UNIT * ((speedSel == 2'd0) ? 2 : (int'(speedSel) + 1)));
    leadLen = halfLen << 1;
  end

  assign tick     = (divCnt == halfLen - DIV_W'(1));
  assign leadDone = (divCnt == leadLen - DIV_W'(1));
  assign lastByte = (byteIdx == lastIdx);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    strobe = '0;
    case (state)
      ST_IDLE: strobe.loadOp = startReq;
      ST_LOW:  strobe.sample = tick;
      ST_HIGH: begin
        if (tick) begin
          if (bitCnt == 3'd7) begin
            strobe.storeRx  = (byteIdx != '0);
            strobe.loadNext = !lastByte;
          end else begin
            strobe.shiftOut = 1'b1;
          end
        end
      end
      default: strobe = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      spiSck  <= 1'b0;
      spiCsN  <= 1'b1;
      bitCnt  <= '0;
      byteIdx <= '0;
      lastIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startReq) begin
            state   <= ST_LEAD;
            spiCsN  <= 1'b0;
            divCnt  <= '0;
            bitCnt  <= '0;
            byteIdx <= '0;
            lastIdx <= BYTE_W'(txCount) + BYTE_W'(rxCount);
          end
        end
        ST_LEAD: begin
          if (leadDone) begin
            state  <= ST_LOW;
            divCnt <= '0;
          end else divCnt <= divCnt + DIV_W'(1);
        end
        ST_LOW: begin
          if (tick) begin
            spiSck <= 1'b1;
            state  <= ST_HIGH;
            divCnt <= '0;
          end else divCnt <= divCnt + DIV_W'(1);
        end
        ST_HIGH: begin
          if (tick) begin
            spiSck <= 1'b0;
            divCnt <= '0;
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7 && lastByte) begin
              state <= ST_TAIL;
            end else begin
              state <= ST_LOW;
              if (bitCnt == 3'd7) byteIdx <= byteIdx + BYTE_W'(1);
            end
          end else divCnt <= divCnt + DIV_W'(1);
        end
        ST_TAIL: begin
          if (tick) begin
            spiCsN <= 1'b1;
            state  <= ST_IDLE;
            divCnt <= '0;
          end else divCnt <= divCnt + DIV_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_eng_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int HALF_UNIT = 1,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] regSel,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       busy,
  output logic       spiSck,
  output logic       spiCsN,
  output logic       spiMosi,
  input  logic       spiMiso
);

  dpStrobe_t        strobe;
  logic             startReq;
  logic [CNT_W-1:0] txCount;
  logic [CNT_W-1:0] rxCount;
  logic [1:0]       speedSel;
  logic [PTR_W-1:0] ptrQ;
  logic [7:0]       cntQ;

  spi_eng_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .busy(busy), .strobe(strobe),
    .spiMiso(spiMiso), .spiMosi(spiMosi), .startReq(startReq),
    .txCount(txCount), .rxCount(rxCount), .speedSel(speedSel),
    .ptrQ(ptrQ), .cntQ(cntQ)
  );

  spi_eng_ctrl #(.MAX_BYTES(DEPTH), .HALF_UNIT(HALF_UNIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .txCount(txCount),
    .rxCount(rxCount), .speedSel(speedSel), .strobe(strobe), .busy(busy),
    .spiSck(spiSck), .spiCsN(spiCsN)
  );

endmodule

// File: rtl/spi_eng_chk.sv
module spi_eng_chk #(
  parameter int PTR_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic [3:0]       regSel,
  input logic             wrEn,
  input logic [7:0]       wrData,
  input logic             busy,
  input logic             spiSck,
  input logic             spiCsN,
  input logic             spiMosi,
  input logic [PTR_W-1:0] ptrQ,
  input logic [7:0]       cntQ
);

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSck); // R10

  AST_CS_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !spiCsN |-> busy); // R4

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == 4'h2 && wrData[0] && !busy) |=> busy); // R4

  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == 4'h2 && wrData[4] && !busy) |=> (ptrQ == '0)); // R3

  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(cntQ)); // R9

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (!spiCsN && spiSck && $past(spiSck)) |-> $stable(spiMosi)); // R5

endmodule

bind spi_cmd_engine spi_eng_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
  .busy(busy), .spiSck(spiSck), .spiCsN(spiCsN), .spiMosi(spiMosi),
  .ptrQ(ptrQ), .cntQ(cntQ)
);

// File: tb/tb_spi_cmd_engine.sv
module tb_spi_cmd_engine;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {opcode[25:18], W[17:14], R[13:10], speed[9:8], seed[7:0]}
  localparam logic [25:0] VEC [NVEC] = '{
    {8'h9F, 4'd0, 4'd3, 2'd1, 8'h00},
    {8'h03, 4'd3, 4'd4, 2'd2, 8'h10},
    {8'h02, 4'd5, 4'd0, 2'd1, 8'h40},
    {8'h0B, 4'd4, 4'd8, 2'd3, 8'h70},
    {8'h05, 4'd0, 4'd1, 2'd0, 8'h00},
    {8'hAB, 4'd8, 4'd8, 2'd1, 8'hC0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] regSel = '0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       busy, spiSck, spiCsN, spiMosi, spiMiso;

  int checks = 0;
  int errors = 0;
  logic [7:0] shadow [8];

  spi_cmd_engine dut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .busy(busy), .spiSck(spiSck),
    .spiCsN(spiCsN), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // ---------------- flash model ----------------
  function automatic logic [7:0] respByte(input int k);
    return 8'h3C ^ 8'(k * 29);
  endfunction

  int         fBits = 0;
  int         fDone = 0;
  logic [7:0] fShift = '0;
  logic [7:0] fSeen [32];
  time        tCs = 0, tRise0 = 0, tRise1 = 0;

  always @(negedge spiSck or posedge spiCsN) begin
    if (spiCsN) fBits = 0;
    else        fBits = fBits + 1;
  end

  always @(negedge spiCsN) tCs = $time;

  always @(posedge spiSck) begin
    if (fBits == 0) tRise0 = $time;
    if (fBits == 1) tRise1 = $time;
    fShift = {fShift[6:0], spiMosi};
    if (fBits % 8 == 7) fSeen[fBits / 8] = fShift;
    fDone = (fBits + 1) / 8;
  end

  assign spiMiso = respByte(fBits / 8)[7 - (fBits % 8)];

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regSel = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    regSel = a; rdEn = 1'b1;
    #1 d = rdData;
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic shadowUpdate(input int p0, input int w, input int r);
    for (int k = 1; k <= w + r; k++) shadow[(p0 + k - 1) % 8] = respByte(k);
  endtask

  task automatic checkRing(input string req);
    logic [7:0] d;
    hostWrite(4'h2, 8'h10);
    for (int i = 0; i < 8; i++) begin
      hostRead(4'hC, d);
      check(d == shadow[i], req, d, shadow[i]);
    end
  endtask

  function automatic int clampN(input int n);
    return (n > 8) ? 8 : n;
  endfunction

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    @(negedge clk);
    check(spiCsN == 1'b1, "R1 csN", spiCsN, 1);
    check(spiSck == 1'b0, "R1 sck", spiSck, 0);
    check(busy == 1'b0, "R1 busy", busy, 0);
    hostRead(4'hD, d);
    check(d == 8'h10, "R1 ptr/speed", d, 8'h10);
    hostRead(4'h2, d);
    check(d == 8'h00, "R1 ctrl", d, 0);

    // R2 fill nine bytes, last one wraps onto slot 0
    for (int i = 0; i < 9; i++) begin
      hostWrite(4'hC, 8'h80 + 8'(i));
      shadow[i % 8] = 8'h80 + 8'(i);
    end
    hostRead(4'hD, d);
    check(d[2:0] == 3'd1, "R2 ptr wrap", d[2:0], 1);
    checkRing("R2 ring readback");
    hostRead(4'hD, d);
    check(d[2:0] == 3'd0, "R2 ptr after 8 reads", d[2:0], 0);

    // table-driven commands
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] op, seed; logic [3:0] w, r; logic [1:0] spd;
      int h;
      {op, w, r, spd, seed} = VEC[v];
      h = (spd == 0) ? 2 : int'(spd) + 1;
      hostWrite(4'h2, 8'h10);
      for (int i = 0; i < int'(w); i++) begin
        hostWrite(4'hC, seed + 8'(i));
        shadow[i] = seed + 8'(i);
      end
      hostWrite(4'h2, 8'h10);
      hostWrite(4'h0, op);
      hostWrite(4'h1, {r, w});
      hostWrite(4'hD, {2'b00, spd, 4'h0});
      hostWrite(4'h2, 8'h01);
      waitIdle();
      check(fSeen[0] == op, "R5 opcode first", fSeen[0], op);
      for (int k = 1; k <= int'(w); k++)
        check(fSeen[k] == seed + 8'(k - 1), "R5 payload", fSeen[k], seed + 8'(k - 1));
      check(fDone == 1 + int'(w) + int'(r), "R6 byte total", fDone, 1 + w + r);
      check((tRise1 - tRise0) / CLK_PERIOD == 2 * h, "R8 sck period",
            int'((tRise1 - tRise0) / CLK_PERIOD), 2 * h);
      check((tRise0 - tCs) / CLK_PERIOD >= 2 * h, "R10 cs lead",
            int'((tRise0 - tCs) / CLK_PERIOD), 2 * h);
      hostRead(4'hD, d);
      check(int'(d[2:0]) == (int'(w) + int'(r)) % 8, "R6 final ptr", d[2:0], (w + r) % 8);
      hostRead(4'h1, d);
      check(d == {r, w}, "R7 count readback", d, {r, w});
      shadowUpdate(0, int'(w), int'(r));
      checkRing("R6 captured data");
    end

    // R7 clamp: W field 15 sends 8 payload bytes
    hostWrite(4'h2, 8'h10);
    hostWrite(4'h0, 8'h20);
    hostWrite(4'h1, 8'h0F);
    hostWrite(4'hD, 8'h10);
    hostWrite(4'h2, 8'h01);
    waitIdle();
    check(fDone == 9, "R7 clamp bytes", fDone, 9);
    hostRead(4'h1, d);
    check(d == 8'h0F, "R7 clamp readback", d, 8'h0F);
    shadowUpdate(0, 8, 0);

    // R9 accesses while busy are ignored; R4 busy bit reads back
    hostWrite(4'h2, 8'h10);
    hostWrite(4'h0, 8'h6B);
    hostWrite(4'h1, 8'h80);
    hostWrite(4'hD, 8'h30);
    hostWrite(4'h2, 8'h01);
    hostRead(4'h2, d);
    check(d[0] == 1'b1, "R4 busy bit set", d[0], 1);
    check(busy == 1'b1, "R4 busy port", busy, 1);
    hostWrite(4'h1, 8'h11);
    hostWrite(4'h0, 8'h00);
    hostWrite(4'hC, 8'hEE);
    hostWrite(4'h2, 8'h10);
    hostRead(4'hC, d);
    waitIdle();
    hostRead(4'h2, d);
    check(d[0] == 1'b0, "R4 busy bit clear", d[0], 0);
    hostRead(4'h1, d);
    check(d == 8'h80, "R9 count kept", d, 8'h80);
    check(fSeen[0] == 8'h6B, "R9 opcode kept", fSeen[0], 8'h6B);
    hostRead(4'hD, d);
    check(d == 8'h30, "R9 ptr and speed kept", d, 8'h30);
    shadowUpdate(0, 0, 8);
    checkRing("R9 ring untouched by host");

    // R3 pointer clear and start in one write
    hostWrite(4'hD, 8'h10);
    hostWrite(4'h2, 8'h10);
    for (int i = 0; i < 3; i++) begin
      hostWrite(4'hC, 8'hD0 + 8'(i));
      shadow[i] = 8'hD0 + 8'(i);
    end
    hostWrite(4'h0, 8'h3B);
    hostWrite(4'h1, 8'h22);
    hostWrite(4'h2, 8'h11);
    waitIdle();
    check(fSeen[1] == shadow[0], "R3 payload from slot 0", fSeen[1], shadow[0]);
    check(fSeen[2] == shadow[1], "R3 payload from slot 1", fSeen[2], shadow[1]);
    hostRead(4'hD, d);
    check(d[2:0] == 3'd4, "R3 final ptr", d[2:0], 4);
    check(spiCsN == 1'b1 && spiSck == 1'b0, "R10 idle lines", {spiCsN, spiSck}, 2'b10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R4 actual=busy expected=idle");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule